// File: doc/BRIEF.md
# Synchronous Serial Port Controller

This block moves one byte at a time over a three-wire clocked serial link made of a serial clock, a data input and a data output. Data is shifted out most significant bit first on each falling clock edge. The input line is sampled on each rising edge. After eight rising edges the received byte sits in a parallel register. The clock either comes from an on-block divider (internal mode, where the block drives the clock pin) or from the far end (external mode). In external mode the clock pin is passed through a synchronizer and an edge detector running on the system clock.

A small state machine has four states: waiting for a start command, waiting for the first serial clock, transferring, and free-running clock output. The host drives it with single-cycle strobes. A mode write latches the clock source and a two-bit pin-mode field, and always returns the machine to start-wait. A start command loads the transmit byte and arms the port. A clear strobe drops the interrupt flag. Every way out of a transfer raises the interrupt flag.

In internal mode with the pin-mode field at zero, the block toggles the clock continuously and moves no data. This is meant for clocking external logic. When no transfer is running, the data output follows a host-supplied idle level.

Top module: `ssp_port`

## Requirements
- R1: After reset the port waits for a start command, the interrupt flag is low, internal clock mode is selected with the pin-mode field at 01, the clock pin is driven (sck_oe high) and held high, and so equals idle_lvl.
- R2: A start command in start-wait loads tx_data and arms the port. The next serial clock falling edge begins a transfer. Bit 7 down to bit 0 of tx_data appear on so, one per falling edge. si is sampled on each rising edge into a shift register that fills from bit 0 upward. After the eighth rising edge, rx_data holds the received byte with the first sampled bit in bit 7.
- R3: In external clock mode (mode_ext written as 1), completing a byte re-arms the port without a new start command. The next falling edge starts another transfer, which shifts out the byte just received.
- R4: In internal clock mode (mode_ext written as 0) with pin-mode field not 00, the divider makes exactly eight clock pulses per byte, each half period HALF_DIV system clocks. The clock pin then stays high, and the port waits for a new start command.
- R5: A start command during a transfer ends it, resets the bit counter to zero, reloads tx_data and re-arms the port. The following eight clocks then carry a complete byte.
- R6: A mode write during a transfer ends it and returns the port to start-wait. Later serial clock edges are ignored: the interrupt flag stays low and rx_data is unchanged.
- R7: A mode write while armed returns the port to start-wait, so later external clock edges start no transfer.
- R8: Every exit from a transfer sets irq, whether by eight clocks, a start command or a mode write. irq stays low during the first seven clocks of a byte. irq stays set until an irq_clr strobe.
- R9: In internal mode with pin-mode field 00, a start command makes the clock toggle without end. No data moves, irq stays low and so follows idle_lvl. A mode write stops the clock with the pin high.
- R10: Outside a transfer so equals idle_lvl. During a transfer idle_lvl has no effect on so.
- R11: The clock pin output enable sck_oe is low in external mode and high in internal mode, taking the value latched by the latest mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_ext | input | 1 | Clock source written on mode_wr: 1 external, 0 internal |
| mode_pin | input | 2 | Pin-mode field written on mode_wr; 00 selects free-running clock in internal mode |
| start | input | 1 | Start command strobe |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| idle_lvl | input | 1 | Level of so outside a transfer |
| tx_data | input | 8 | Byte loaded by a start command |
| rx_data | output | 8 | Last completely received byte |
| irq | output | 1 | Serial interrupt request flag |
| sck_in | input | 1 | Serial clock from the far end (external mode) |
| sck_out | output | 1 | Generated serial clock (internal mode) |
| sck_oe | output | 1 | Output enable for the clock pin |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output |

## Verification
The bench builds the port with HALF_DIV set to 3, so one internal byte takes 48 system clocks. At that rate a free-running clock run of more than thirty pulses, followed by the checks that the clock has stopped, fits in a few hundred cycles. The data width and the two-stage synchronizer keep their default values. The bench holds each external clock phase for six system clocks, so the synchronizer delay never hides an edge. This makes it possible to abort a transfer with a start command or mode write at a chosen bit position.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SHIFT = 2'd2,
    ST_FREE  = 2'd3
  } ssp_state_e;

  // state taken after the last bit of a byte
  function automatic ssp_state_e after_byte(input logic ext);
    return ext ? ST_ARMED : ST_IDLE;
  endfunction

  // free-running clock is chosen only with the internal source and pin field 00
  function automatic logic free_run_sel(input logic ext, input logic [1:0] pin);
    return !ext && (pin == 2'b00);
  endfunction

  // position of the next received bit in the shift register
  function automatic logic [7:0] shift_in8(input logic [7:0] cur, input logic b);
    return {cur[6:0], b};
  endfunction

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic fall_ev,
  output logic rise_ev
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             tick;

  assign tick    = run && (div_q == DIV_LAST);
  assign fall_ev = tick && sck;
  assign rise_ev = tick && !sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sck   <= 1'b1;
    end else if (!run) begin
      div_q <= '0;
      sck   <= 1'b1;
    end else if (tick) begin
      div_q <= '0;
      sck   <= ~sck;
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end

  // R4
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> sck);

endmodule

// File: rtl/ssp_edge_sync.sv
module ssp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  chain_q[g] <= 1'b1;
      else if (g == 0) chain_q[g] <= pin;
      else         chain_q[g] <= chain_q[(g > 0) ? g - 1 : 0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign fall_o = prev_q && !chain_q[STAGES-1];
  assign rise_o = !prev_q && chain_q[STAGES-1];

  // R2
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter import ssp_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ev,
  input  logic              drive_ev,
  input  logic              sample_ev,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              si,
  output logic              so_bit,
  output logic [DATA_W-1:0] rx_data
);
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_next;

  assign sh_next = {sh_q[DATA_W-2:0], si};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      so_bit  <= 1'b0;
      rx_data <= '0;
    end else begin
      if (load_ev)        sh_q <= tx_data;
      else if (sample_ev) sh_q <= sh_next;
      if (drive_ev)       so_bit <= sh_q[DATA_W-1];
      if (byte_done)      rx_data <= sh_next;
    end
  end

  // R2
  load_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (rx_data == sh_q));

endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl import ssp_pkg::*; #(
  parameter int         DATA_W   = 8,
  parameter logic [1:0] PIN_INIT = 2'b01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic       mode_ext,
  input  logic [1:0] mode_pin,
  input  logic       start,
  input  logic       irq_clr,
  input  logic       fall_ev,
  input  logic       rise_ev,
  output ssp_state_e state,
  output logic       ext_mode,
  output logic       drive_ev,
  output logic       sample_ev,
  output logic       load_ev,
  output logic       byte_done,
  output logic       irq
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  ssp_state_e       st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       pin_q;
  logic             exit_ev;

  always_comb begin
    st_d      = state;
    cnt_d     = cnt_q;
    drive_ev  = 1'b0;
    sample_ev = 1'b0;
    load_ev   = 1'b0;
    byte_done = 1'b0;
    exit_ev   = 1'b0;
    if (mode_wr) begin
      st_d    = ST_IDLE;
      cnt_d   = '0;
      exit_ev = (state == ST_SHIFT);
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          st_d    = ST_ARMED;
          load_ev = 1'b1;
        end
        ST_ARMED: begin
          if (start) load_ev = 1'b1;
          else if (fall_ev) begin
            if (free_run_sel(ext_mode, pin_q)) st_d = ST_FREE;
            else begin
              st_d     = ST_SHIFT;
              drive_ev = 1'b1;
            end
          end
        end
        ST_SHIFT: begin
          if (start) begin
            st_d    = ST_ARMED;
            load_ev = 1'b1;
            cnt_d   = '0;
            exit_ev = 1'b1;
          end else if (rise_ev) begin
            sample_ev = 1'b1;
            if (cnt_q == CNT_LAST) begin
              cnt_d     = '0;
              st_d      = after_byte(ext_mode);
              byte_done = 1'b1;
              exit_ev   = 1'b1;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end else if (fall_ev) begin
            drive_ev = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt_q    <= '0;
      ext_mode <= 1'b0;
      pin_q    <= PIN_INIT;
      irq      <= 1'b0;
    end else begin
      state <= st_d;
      cnt_q <= cnt_d;
      if (mode_wr) begin
        ext_mode <= mode_ext;
        pin_q    <= mode_pin;
      end
      if (exit_ev)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  // R6
  mode_wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (state == ST_IDLE));

  // R8
  exit_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && st_d != ST_SHIFT) |=> irq);

  // R3
  byte_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (state == (ext_mode ? ST_ARMED : ST_IDLE)));

  // R9
  free_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FREE) |-> !ext_mode);

  // R5
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_SHIFT) |-> (cnt_q == '0));

endmodule

// File: rtl/ssp_port.sv
module ssp_port import ssp_pkg::*; #(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4,
  parameter int STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic              mode_ext,
  input  logic [1:0]        mode_pin,
  input  logic              start,
  input  logic              irq_clr,
  input  logic              idle_lvl,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              irq,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              si,
  output logic              so
);
  ssp_state_e state;
  logic ext_mode, run;
  logic int_fall, int_rise, ext_fall, ext_rise, fall_ev, rise_ev;
  logic drive_ev, sample_ev, load_ev, byte_done, so_bit;

  assign run     = !ext_mode && (state != ST_IDLE);
  assign fall_ev = ext_mode ? ext_fall : int_fall;
  assign rise_ev = ext_mode ? ext_rise : int_rise;
  assign sck_oe  = !ext_mode;
  assign so      = (state == ST_SHIFT) ? so_bit : idle_lvl;

  ssp_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sck(sck_out), .fall_ev(int_fall), .rise_ev(int_rise)
  );

  ssp_edge_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(sck_in),
    .fall_o(ext_fall), .rise_o(ext_rise)
  );

  ssp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_ext(mode_ext),
    .mode_pin(mode_pin), .start(start), .irq_clr(irq_clr),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .state(state), .ext_mode(ext_mode),
    .drive_ev(drive_ev), .sample_ev(sample_ev), .load_ev(load_ev),
    .byte_done(byte_done), .irq(irq)
  );

  ssp_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_ev(load_ev), .drive_ev(drive_ev),
    .sample_ev(sample_ev), .byte_done(byte_done), .tx_data(tx_data),
    .si(si), .so_bit(so_bit), .rx_data(rx_data)
  );

  // R10
  so_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && $past(state) == ST_SHIFT && !$past(drive_ev))
      |-> $stable(so));

endmodule

// File: tb/ssp_port_test.sv
module ssp_port_test;
  localparam int TCLK = 10;
  localparam int PH   = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_wr = 0, mode_ext = 0, start = 0, irq_clr = 0, idle_lvl = 1;
  logic [1:0] mode_pin = 2'b01;
  logic [7:0] tx_data = 8'h00, rx_data;
  logic irq, sck_in = 1, sck_out, sck_oe, si = 0, so;

  int nvec = 0, nfail = 0;
  logic so_q[$];
  event mon_ev;
  logic int_q[$];
  logic [7:0] si_pat = 8'h00;
  int si_idx = 8;
  int falls = 0;
  logic prev_sck = 1'b1;
  bit finished = 0;

  always #(TCLK/2) clk = ~clk;

  ssp_port #(.DATA_W(8), .HALF_DIV(3), .STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_ext(mode_ext),
    .mode_pin(mode_pin), .start(start), .irq_clr(irq_clr), .idle_lvl(idle_lvl),
    .tx_data(tx_data), .rx_data(rx_data), .irq(irq), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .si(si), .so(so)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mode(input logic ext, input logic [1:0] pin);
    @(negedge clk); mode_wr = 1; mode_ext = ext; mode_pin = pin;
    @(negedge clk); mode_wr = 0;
    wait_n(2);
  endtask

  task automatic pulse_start(input logic [7:0] d);
    @(negedge clk); start = 1; tx_data = d;
    @(negedge clk); start = 0;
    wait_n(2);
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  // driver: one external clock with an expected so bit pushed to the scoreboard
  task automatic ext_bit(input logic exp_so, input logic si_b, input bit poke_idle);
    @(negedge clk); sck_in = 0;
    wait_n(PH);
    so_q.push_back(exp_so);
    -> mon_ev;
    si = si_b;
    if (poke_idle) begin
      idle_lvl = ~idle_lvl;
      wait_n(2);
      check("R10 so ignores idle_lvl", so, exp_so);
    end
    wait_n(PH);
    sck_in = 1;
    wait_n(PH);
  endtask

  task automatic ext_raw(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sck_in = 0;
      wait_n(PH);
      sck_in = 1;
      wait_n(PH);
    end
  endtask

  // monitor for external transfers
  initial begin
    forever begin
      @(mon_ev);
      #1;
      while (so_q.size() > 0) begin
        logic e;
        e = so_q.pop_front();
        check("R2 so bit", so, e);
      end
    end
  end

  // monitor for the generated clock
  always @(negedge clk) begin
    if (prev_sck && !sck_out) begin
      falls++;
      if (int_q.size() > 0) begin
        logic e;
        e = int_q.pop_front();
        check("R4 so bit internal", so, e);
      end
      if (si_idx < 8) begin
        si = si_pat[7 - si_idx];
        si_idx++;
      end
    end
    prev_sck = sck_out;
  end

  initial begin
    #(TCLK * 200000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] txb, sib;
    int f0;
    wait_n(5);
    rst_n = 1;
    wait_n(2);
    // R1
    check("R1 irq", irq, 0);
    check("R1 so", so, 1);
    check("R1 sck_out", sck_out, 1);
    check("R1 sck_oe", sck_oe, 1);
    // R10 idle level follows
    idle_lvl = 0; wait_n(1);
    check("R10 so idle", so, 0);
    idle_lvl = 1; wait_n(1);
    check("R10 so idle", so, 1);

    // R11
    write_mode(1, 2'b01);
    check("R11 sck_oe external", sck_oe, 0);

    // R2 external byte
    txb = 8'hA5; sib = 8'h3C;
    pulse_start(txb);
    check("R2 so before first edge", so, idle_lvl);
    for (int i = 0; i < 7; i++) ext_bit(txb[7-i], sib[7-i], i == 3);
    check("R8 irq low after 7 clocks", irq, 0);
    ext_bit(txb[0], sib[0], 0);
    check("R8 irq set after byte", irq, 1);
    check("R2 rx_data", rx_data, 8'h3C);
    pulse_clr(); wait_n(1);
    check("R8 irq cleared", irq, 0);

    // R3 external re-arm without start: shifts out received byte
    txb = 8'h3C; sib = 8'h5A;
    for (int i = 0; i < 8; i++) ext_bit(txb[7-i], sib[7-i], 0);
    check("R3 irq", irq, 1);
    check("R3 rx_data", rx_data, 8'h5A);
    pulse_clr();

    // R5 start during transfer
    txb = 8'hC3;
    pulse_start(txb);
    for (int i = 0; i < 3; i++) ext_bit(txb[7-i], 1'b0, 0);
    check("R5 irq low mid byte", irq, 0);
    pulse_start(8'h81);
    check("R5 irq on abort", irq, 1);
    check("R5 so idle after abort", so, idle_lvl);
    pulse_clr();
    txb = 8'h81; sib = 8'hE7;
    for (int i = 0; i < 7; i++) ext_bit(txb[7-i], sib[7-i], 0);
    check("R5 counter restarted", irq, 0);
    ext_bit(txb[0], sib[0], 0);
    check("R5 irq after full byte", irq, 1);
    check("R5 rx_data", rx_data, 8'hE7);
    pulse_clr();

    // R6 mode write during transfer
    txb = 8'hFF;
    pulse_start(txb);
    for (int i = 0; i < 2; i++) ext_bit(txb[7-i], 1'b1, 0);
    write_mode(1, 2'b01);
    check("R6 irq on mode write", irq, 1);
    idle_lvl = 0; wait_n(1);
    check("R6 so idle", so, 0);
    pulse_clr();
    ext_raw(9);
    check("R6 edges ignored irq", irq, 0);
    check("R6 edges ignored rx", rx_data, 8'hE7);
    check("R6 so stays idle", so, 0);

    // R7 mode write while armed
    pulse_start(8'h0F);
    write_mode(1, 2'b01);
    ext_raw(9);
    check("R7 irq", irq, 0);
    check("R7 rx", rx_data, 8'hE7);

    // R4 internal byte
    idle_lvl = 1;
    write_mode(0, 2'b01);
    check("R11 sck_oe internal", sck_oe, 1);
    txb = 8'h5B;
    for (int i = 0; i < 8; i++) int_q.push_back(txb[7-i]);
    si_pat = 8'h96; si_idx = 0;
    f0 = falls;
    pulse_start(txb);
    wait_n(120);
    check("R4 pulse count", falls - f0, 8);
    check("R4 rx_data", rx_data, 8'h96);
    check("R4 irq", irq, 1);
    check("R4 queue drained", int_q.size(), 0);
    wait_n(80);
    check("R4 clock stopped", falls - f0, 8);
    check("R4 sck high", sck_out, 1);
    pulse_clr();

    // R9 continuous clock
    write_mode(0, 2'b00);
    f0 = falls;
    pulse_start(8'hAA);
    wait_n(200);
    check("R9 many pulses", (falls - f0) > 20, 1);
    check("R9 irq low", irq, 0);
    check("R9 rx unchanged", rx_data, 8'h96);
    check("R9 so idle", so, 1);
    idle_lvl = 0; wait_n(1);
    check("R9 so follows idle", so, 0);
    write_mode(0, 2'b01);
    wait_n(4);
    f0 = falls;
    wait_n(50);
    check("R9 clock stopped", falls - f0, 0);
    check("R9 sck high", sck_out, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule